// File: doc/BRIEF.md
# Serial Controller State and Error Register

This block holds the run-state bits and the sticky error flags of a serial controller. There are two state bits: an operating enable, where 0 is configuration mode and 1 is operational mode, and a master-select bit. There are also six error flags: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software cannot write these bits as plain data. Each bit has a dedicated set command bit and a dedicated clear command bit in a 16-bit command word, and software changes the bits by writing that word.

The controller datapath reports error events as single-cycle pulses. A pulse latches its flag only when the matching enable bit in the controller's control word is on. The one exception is the mode error, which latches whenever its event is seen. The block presents a status word for reads and drives an error interrupt that stays high while any flag is set.

The block contains no bus decode. It has one command-write strobe with its data, and one read word.

Top module: `serst_state_reg`

## Requirements
- R1: After reset every state bit and flag reads 0, so the block starts in configuration mode with master select clear and the interrupt low.
- R2: With `cmd_wr` high, command bit 1 sets the enable and bit 0 clears it. Bit 3 sets master select and bit 2 clears it.
- R3: With `cmd_wr` high, the error flags are cleared by these command bits: receive underflow by bit 4, mode error by bit 6, transmit overflow by bit 8, receive overflow by bit 9, abort by bit 10 and transmit underflow by bit 11.
- R4: With `cmd_wr` high, the error flags are set by these command bits: receive underflow by bit 5, mode error by bit 7, transmit overflow by bit 12, receive overflow by bit 13, abort by bit 14 and transmit underflow by bit 15.
- R5: When a set bit and its clear bit are both 1 in the same write, the state bit ends up 0.
- R6: `hw_err_evt` bits 0 to 5 carry the mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow events. A mode-error event always sets its flag. Each of the other events sets its flag only when its enable is 1 in `ctrl_word`: bit 8 for transmit overflow, bit 9 for receive overflow, bit 10 for abort, bit 11 for transmit underflow and bit 12 for receive underflow.
- R7: An event whose enable is 0 leaves its flag unchanged.
- R8: An enabled event in the same cycle as a software clear of that flag leaves the flag at 1.
- R9: `status_word` carries these fields: enable at bit 0, master select at bit 1, and the mode, transmit overflow, receive overflow, abort, transmit underflow and receive underflow flags at bits 7 to 12. Bit 13 follows `busy_in` in the same cycle, and every other bit reads 0.
- R10: `err_irq` is 1 exactly when at least one of the six error flags is 1.
- R11: When `cmd_wr` is low and no event is present, all state holds, whatever `cmd_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_data | input | 16 | Command word of set and clear bits |
| ctrl_word | input | 16 | Controller control word; bits 8 to 12 are the error enables |
| hw_err_evt | input | 6 | Error event pulses from the datapath |
| busy_in | input | 1 | Busy indication passed through to the status word |
| status_word | output | 16 | Status read word |
| op_enable | output | 1 | Operating enable (1 = operational mode) |
| master_sel | output | 1 | Master-select state |
| err_irq | output | 1 | Error interrupt |

## Verification
The properties need only that `rst_n` is released synchronously and that every input is stable at the clock edge. They place no restriction on which event bits, command bits or enables appear together. Conflicting cases such as set-with-clear and event-with-clear are therefore allowed and checked by the properties themselves. The stimulus changes inputs only on the falling edge. It covers every 16-bit command value in turn, and every combination of enable and event, with and without a simultaneous software clear, so it stays inside these assumptions while reaching each conflict.

// File: rtl/serst_pkg.sv
package serst_pkg;

    localparam int CMD_W     = 16;
    localparam int CTRL_W    = 16;
    localparam int STAT_W    = 16;
    localparam int NUM_ERR   = 6;
    localparam int NUM_STATE = NUM_ERR + 2;

    // Internal state order: 0 enable, 1 master, 2 mode error, 3 tx overflow,
    // 4 rx overflow, 5 abort, 6 tx underflow, 7 rx underflow.
    localparam int CLR_POS  [NUM_STATE] = '{0, 2, 6, 8, 9, 10, 11, 4};
    localparam int SET_POS  [NUM_STATE] = '{1, 3, 7, 12, 13, 14, 15, 5};
    localparam int STAT_POS [NUM_STATE] = '{0, 1, 7, 8, 9, 10, 11, 12};
    // Control-word enable per error flag; -1 means always latched.
    localparam int ENA_POS  [NUM_ERR]   = '{-1, 8, 9, 10, 11, 12};
    localparam int BUSY_POS = 13;

    typedef struct packed {
        logic [NUM_ERR-1:0] err;
        logic               master;
        logic               op_en;
    } state_t;

endpackage

// File: rtl/serst_cmd_decode.sv
module serst_cmd_decode
    import serst_pkg::*;
(
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_data,
    output logic [NUM_STATE-1:0] sw_set,
    output logic [NUM_STATE-1:0] sw_clr
);
    for (genvar i = 0; i < NUM_STATE; i++) begin : g_bit
        assign sw_set[i] = cmd_wr & cmd_data[SET_POS[i]];
        assign sw_clr[i] = cmd_wr & cmd_data[CLR_POS[i]];
    end
endmodule

// File: rtl/serst_evt_gate.sv
module serst_evt_gate
    import serst_pkg::*;
(
    input  logic [CTRL_W-1:0]    ctrl_word,
    input  logic [NUM_ERR-1:0]   hw_err_evt,
    output logic [NUM_STATE-1:0] hw_set
);
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_word;

    // Enable and master bits have no hardware set path.
    assign hw_set[1:0] = 2'b00;

    for (genvar e = 0; e < NUM_ERR; e++) begin : g_evt
        if (ENA_POS[e] < 0) begin : g_always
            assign hw_set[e+2] = hw_err_evt[e];
        end else begin : g_gated
            assign hw_set[e+2] = hw_err_evt[e] & ctrl_word[ENA_POS[e]];
        end
    end
endmodule

// File: rtl/serst_status_pack.sv
module serst_status_pack
    import serst_pkg::*;
(
    input  state_t            st,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status_word,
    output logic              err_irq
);
    logic [NUM_STATE-1:0] flat;
    assign flat = st;

    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_STATE; i++) begin
            status_word[STAT_POS[i]] = flat[i];
        end
        status_word[BUSY_POS] = busy_in;
    end

    assign err_irq = |st.err;
endmodule

// File: rtl/serst_state_reg.sv
module serst_state_reg
    import serst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_data,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic [NUM_ERR-1:0]  hw_err_evt,
    input  logic                busy_in,
    output logic [STAT_W-1:0]   status_word,
    output logic                op_enable,
    output logic                master_sel,
    output logic                err_irq
);
    state_t               state_d, state_q;
    logic [NUM_STATE-1:0] sw_set, sw_clr, hw_set;
    logic [NUM_STATE-1:0] cur_v, nxt_v;

    serst_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr)
    );

    serst_evt_gate u_gate (
        .ctrl_word  (ctrl_word),
        .hw_err_evt (hw_err_evt),
        .hw_set     (hw_set)
    );

    // Priority: hardware set, then software clear, then software set.
    always_comb begin
        cur_v = state_q;
        for (int i = 0; i < NUM_STATE; i++) begin
            if (hw_set[i])      nxt_v[i] = 1'b1;
            else if (sw_clr[i]) nxt_v[i] = 1'b0;
            else if (sw_set[i]) nxt_v[i] = 1'b1;
            else                nxt_v[i] = cur_v[i];
        end
        state_d = state_t'(nxt_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    serst_status_pack u_pack (
        .st          (state_q),
        .busy_in     (busy_in),
        .status_word (status_word),
        .err_irq     (err_irq)
    );

    assign op_enable  = state_q.op_en;
    assign master_sel = state_q.master;
endmodule

// File: rtl/serst_state_reg_chk.sv
module serst_state_reg_chk
    import serst_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic [CMD_W-1:0]   cmd_data,
    input logic [CTRL_W-1:0]  ctrl_word,
    input logic [NUM_ERR-1:0] hw_err_evt,
    input logic               busy_in,
    input logic [STAT_W-1:0]  status_word,
    input logic               op_enable,
    input logic               master_sel,
    input logic               err_irq
);
    assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[1] && !cmd_data[0]) |=> op_enable);

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[8] && cmd_data[12] && !hw_err_evt[1]) |=> !status_word[8]);

    assert_gated_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_word[9] && hw_err_evt[2] && !ctrl_word[9] && !(cmd_wr && cmd_data[13]))
        |=> !status_word[9]);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_err_evt[3] && ctrl_word[10]) |=> status_word[10]);

    assert_mode_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err_evt[0] |=> status_word[7]);

    assert_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] == op_enable) && (status_word[1] == master_sel) &&
        (status_word[13] == busy_in) && (status_word[6:2] == 5'd0) &&
        (status_word[15:14] == 2'd0));

    assert_irq_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (status_word[12:7] != 6'd0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && hw_err_evt == '0) |=> $stable(status_word[12:0] & 13'h1FFF & ~13'h0000)
        || $changed(busy_in));
endmodule

bind serst_state_reg serst_state_reg_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .ctrl_word   (ctrl_word),
    .hw_err_evt  (hw_err_evt),
    .busy_in     (busy_in),
    .status_word (status_word),
    .op_enable   (op_enable),
    .master_sel  (master_sel),
    .err_irq     (err_irq)
);

// File: tb/serst_state_reg_tb_top.sv
module serst_state_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [15:0] ctrl_word = '0;
    logic [5:0]  hw_err_evt = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_word;
    logic        op_enable, master_sel, err_irq;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    // Bench model state: [0] en, [1] ms, [2..7] mode, txo, rxo, abt, txu, rxu
    logic [7:0] mdl = '0;

    always #2.5 clk = ~clk;

    serst_state_reg dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .ctrl_word(ctrl_word), .hw_err_evt(hw_err_evt), .busy_in(busy_in),
        .status_word(status_word), .op_enable(op_enable),
        .master_sel(master_sel), .err_irq(err_irq)
    );

    function automatic int clr_bit(int i);
        case (i) 0: return 0; 1: return 2; 2: return 6; 7: return 4;
            default: return i + 5;  // 3..6 -> 8..11
        endcase
    endfunction

    function automatic int set_bit(int i);
        case (i) 0: return 1; 1: return 3; 2: return 7; 7: return 5;
            default: return i + 9;  // 3..6 -> 12..15
        endcase
    endfunction

    function automatic logic [7:0] model_next(logic [7:0] s, logic wr,
            logic [15:0] d, logic [15:0] c, logic [5:0] ev);
        logic [7:0] n = s;
        for (int i = 0; i < 8; i++) begin
            logic hs = 1'b0;
            if (i == 2) hs = ev[0];
            else if (i > 2) hs = ev[i-2] & c[i+5];
            if (hs) n[i] = 1'b1;
            else if (wr && d[clr_bit(i)]) n[i] = 1'b0;
            else if (wr && d[set_bit(i)]) n[i] = 1'b1;
        end
        return n;
    endfunction

    function automatic logic [15:0] expect_word(logic [7:0] s, logic b);
        logic [15:0] w = '0;
        w[0] = s[0];
        w[1] = s[1];
        w[12:7] = s[7:2];
        w[13] = b;
        return w;
    endfunction

    task automatic check(string req);
        logic [15:0] ew = expect_word(mdl, busy_in);
        logic ei = (mdl[7:2] != 6'd0);
        vectors++;
        if (status_word !== ew || err_irq !== ei || op_enable !== mdl[0] ||
            master_sel !== mdl[1]) begin
            fails++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, status_word, err_irq, ew, ei);
        end
    endtask

    task automatic apply(logic wr, logic [15:0] d, logic [15:0] c,
                         logic [5:0] ev, logic b, string req);
        @(negedge clk);
        cmd_wr = wr; cmd_data = d; ctrl_word = c; hw_err_evt = ev; busy_in = b;
        mdl = model_next(mdl, wr, d, c, ev);
        @(posedge clk);
        #1;
        check(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below 190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release");

        // R2 R3 R4: single command bits from all-set and all-clear states
        for (int b = 0; b < 16; b++) begin
            apply(1'b1, 16'hF0AA, '0, '0, 1'b0, "R4 set all");
            apply(1'b1, 16'(1) << b, '0, '0, 1'b0, "R3 single bit from ones");
            apply(1'b1, 16'h0F55, '0, '0, 1'b1, "R3 clear all");
            apply(1'b1, 16'(1) << b, '0, '0, 1'b0, "R2 single bit from zeros");
        end

        // R5: explicit set+clear conflict, and full command sweep
        apply(1'b1, 16'hFFFF, '0, '0, 1'b0, "R5 all ones write");
        for (int v = 0; v < 65536; v++) begin
            apply(1'b1, 16'(v), '0, '0, v[3], "R2 R3 R4 R5 sweep");
        end

        // R6 R7: every enable/event combination from cleared state
        for (int en = 0; en < 32; en++) begin
            for (int ev = 0; ev < 64; ev++) begin
                apply(1'b1, 16'h0F55, '0, '0, 1'b0, "R3 pre-clear");
                apply(1'b0, '0, 16'(en) << 8, 6'(ev), 1'b0, "R6 R7 gated events");
            end
        end

        // R8: events against a simultaneous clear of every flag
        for (int en = 0; en < 32; en++) begin
            for (int ev = 0; ev < 64; ev++) begin
                apply(1'b1, 16'hF0AA, '0, '0, 1'b0, "R4 pre-set");
                apply(1'b1, 16'h0F55, 16'(en) << 8, 6'(ev), 1'b1, "R8 event vs clear");
            end
        end

        // R9 R10 R11: idle cycles with junk data, busy toggling
        apply(1'b1, 16'h2080, '0, '0, 1'b0, "R10 one flag");
        for (int k = 0; k < 200; k++) begin
            apply(1'b0, 16'($urandom), 16'($urandom), '0, k[0], "R11 hold R9 busy");
        end
        apply(1'b1, 16'h0F55, '0, '0, 1'b0, "R10 cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule